// File: doc/BRIEF.md
# FIFO Status and Interrupt Controller

This block is the host-facing register unit of a rendering engine. It watches the fill level of two queues: an input queue that the host feeds and an output queue that the host drains. It also watches a post-reset initialization phase and a run/sleep indication. It reduces each queue's fill count to a two-bit condition code and publishes these codes in a 16-bit status register. It also holds a 16-bit interrupt mask register. Both registers sit on the low half of a 32-bit data bus.

One level-sensitive interrupt request is formed from the conditions that the mask enables. The host reaches the registers through a plain strobe interface:
- `reg_sel` picks the register.
- `rd_en` drives the selected value onto `rd_data` in the same cycle.
- `wr_en` updates the mask at the next clock edge.

No data streams cross the boundary, so there is no valid/ready handshake and no back-pressure. Every pin is a plain control or status signal.

The queue codes and the sleep bit are registered, so they follow the input counts with one cycle of latency. The initialization flag comes from an internal counter that starts at reset.

Top module: `fifo_stat_irq`

## Requirements
- R1: While reset is held, or right after it, a status read returns 0x0000_0010 (both queue codes empty, init flag set, sleep clear) and a mask read returns 0x0000_000E. `irq` is 0.
- R2: Status bits [15:14] hold the input-queue code one cycle after `in_count` is applied: 00 when the count is 0, 11 when the count is at least IN_DEPTH, and 01 otherwise.
- R3: Status bits [13:12] hold the output-queue code under the same rule, using `out_count` and OUT_DEPTH.
- R4: Status bit 4 reads 1 for exactly INIT_CYCLES rising edges after reset is released. It then reads 0 and stays 0 until the next reset.
- R5: A write with `reg_sel`=1 loads `wr_data[3:0]` into the mask at the next edge. Bits [31:4] of the write are ignored, and a mask read returns 0 in bits [31:4]. The mask holds its value when no such write occurs.
- R6: When mask bit 0 is 1 and the input-queue code is 00, `irq` is 1.
- R7: Mask bits [2:1] select the output-queue interrupt: 11 fires on code 11, 01 fires on code 01, and 00 or 10 never fire.
- R8: When mask bit 3 is 1 and the init flag is 0, `irq` is 1.
- R9: `irq` is the OR of the R6 to R8 conditions. It is a level that stays high on every cycle the condition holds, and it is 0 when the mask is 0.
- R10: Status bits other than 15:12, 4 and 0 read 0, and `rd_data` bits [31:16] are always 0. A write with `reg_sel`=0 changes nothing.
- R11: Status bit 0 shows `sleep_in`, registered one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_count | input | $clog2(IN_DEPTH+1) | Fill count of the input queue |
| out_count | input | $clog2(OUT_DEPTH+1) | Fill count of the output queue |
| sleep_in | input | 1 | Engine sleep indication |
| reg_sel | input | 1 | 0 selects status, 1 selects mask |
| rd_en | input | 1 | Read strobe; `rd_data` is 0 when low |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data (combinational) |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions check several properties on every cycle:
- the queue encoders never produce the unused code 10;
- a full count always yields code 11 one cycle later;
- the init flag never comes back once it has cleared;
- the mask is stable without a write;
- `irq` is forced high by the init-done and input-empty conditions and is low under an all-zero mask;
- the upper half of the read bus stays zero.

Only the bench scenarios can show the exact length of the init phase and the reset values. They also cover the ready boundary of each encoder, each output-select setting, the masking of upper write bits, and the fact that a status write has no effect.

// File: rtl/fsi_pkg.sv
package fsi_pkg;
  typedef enum logic [1:0] {
    FQ_EMPTY = 2'b00,
    FQ_READY = 2'b01,
    FQ_FULL  = 2'b11
  } fq_code_e;

  typedef struct packed {
    logic       init_en;  // bit 3
    logic [1:0] out_sel;  // bits 2:1
    logic       in_en;    // bit 0
  } irq_mask_t;

  localparam irq_mask_t MASK_RST = '{init_en: 1'b1, out_sel: 2'b11, in_en: 1'b0};

  localparam int ST_IN_LO   = 14;
  localparam int ST_OUT_LO  = 12;
  localparam int ST_INIT    = 4;
  localparam int ST_SLEEP   = 0;
endpackage

// File: rtl/fq_encoder.sv
module fq_encoder
  import fsi_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  output fq_code_e      code
);
  fq_code_e code_d;

  always_comb begin
    if (count == '0)                 code_d = FQ_EMPTY;
    else if (count >= CW'(DEPTH))    code_d = FQ_FULL;
    else                             code_d = FQ_READY;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code <= FQ_EMPTY;
    else        code <= code_d;
  end

  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    code != 2'b10); // R2
  AST_FULL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (count >= CW'(DEPTH)) |=> (code == FQ_FULL)); // R3
endmodule

// File: rtl/init_seq.sv
module init_seq #(
  parameter int INIT_CYCLES = 8,
  localparam int CNTW = (INIT_CYCLES > 0) ? $clog2(INIT_CYCLES + 1) : 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic busy
);
  generate
    if (INIT_CYCLES == 0) begin : g_none
      assign busy = 1'b0;
    end else begin : g_count
      logic [CNTW-1:0] remain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            remain <= CNTW'(INIT_CYCLES);
        else if (remain != '0) remain <= remain - CNTW'(1);
      end
      assign busy = (remain != '0);
    end
  endgenerate

  AST_INIT_STAYS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !busy); // R4
endmodule

// File: rtl/mask_reg.sv
module mask_reg
  import fsi_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [3:0]  wdata,
  output irq_mask_t   mask_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  mask_q <= MASK_RST;
    else if (wr) mask_q <= irq_mask_t'(wdata);
  end

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(mask_q)); // R5
endmodule

// File: rtl/fifo_stat_irq.sv
module fifo_stat_irq
  import fsi_pkg::*;
#(
  parameter int IN_DEPTH    = 16,
  parameter int OUT_DEPTH   = 16,
  parameter int INIT_CYCLES = 8,
  localparam int ICW = $clog2(IN_DEPTH + 1),
  localparam int OCW = $clog2(OUT_DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [ICW-1:0] in_count,
  input  logic [OCW-1:0] out_count,
  input  logic           sleep_in,
  input  logic           reg_sel,
  input  logic           rd_en,
  input  logic           wr_en,
  input  logic [31:0]    wr_data,
  output logic [31:0]    rd_data,
  output logic           irq
);
  fq_code_e  in_code, out_code;
  logic      init_busy;
  logic      sleep_q;
  irq_mask_t mask_q;
  logic [15:0] status;
  logic      in_hit, out_hit, init_hit;

  fq_encoder #(.DEPTH(IN_DEPTH))  u_in_enc  (.clk, .rst_n, .count(in_count),  .code(in_code));
  fq_encoder #(.DEPTH(OUT_DEPTH)) u_out_enc (.clk, .rst_n, .count(out_count), .code(out_code));
  init_seq   #(.INIT_CYCLES(INIT_CYCLES)) u_init (.clk, .rst_n, .busy(init_busy));
  mask_reg   u_mask (.clk, .rst_n, .wr(wr_en && reg_sel), .wdata(wr_data[3:0]), .mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sleep_q <= 1'b0;
    else        sleep_q <= sleep_in;
  end

  always_comb begin
    status = '0;
    status[ST_IN_LO +: 2]  = in_code;
    status[ST_OUT_LO +: 2] = out_code;
    status[ST_INIT]        = init_busy;
    status[ST_SLEEP]       = sleep_q;
  end

  always_comb begin
    in_hit   = mask_q.in_en && (in_code == FQ_EMPTY);
    unique case (mask_q.out_sel)
      2'b11:   out_hit = (out_code == FQ_FULL);
      2'b01:   out_hit = (out_code == FQ_READY);
      default: out_hit = 1'b0;
    endcase
    init_hit = mask_q.init_en && !init_busy;
  end

  assign irq = in_hit || out_hit || init_hit;

  always_comb begin
    rd_data = '0;
    if (rd_en) rd_data[15:0] = reg_sel ? {12'b0, mask_q} : status;
  end

  AST_IRQ_INIT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q.init_en && !init_busy) |-> irq); // R8
  AST_IRQ_IN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q.in_en && status[ST_IN_LO +: 2] == 2'b00) |-> irq); // R6
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq); // R9
  AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[31:16] == 16'h0); // R10
endmodule

// File: tb/fifo_stat_irq_test.sv
module fifo_stat_irq_test;
  localparam int IN_DEPTH = 16, OUT_DEPTH = 16, INIT_CYCLES = 8;
  localparam int ICW = $clog2(IN_DEPTH + 1), OCW = $clog2(OUT_DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [ICW-1:0] in_count = '0;
  logic [OCW-1:0] out_count = '0;
  logic sleep_in = 1'b0, reg_sel = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [31:0] wr_data = '0, rd_data;
  logic irq;

  int checks = 0, fails = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit done = 0;

  always #5 clk = ~clk;

  fifo_stat_irq #(.IN_DEPTH(IN_DEPTH), .OUT_DEPTH(OUT_DEPTH), .INIT_CYCLES(INIT_CYCLES)) uut (
    .clk, .rst_n, .in_count, .out_count, .sleep_in, .reg_sel, .rd_en, .wr_en,
    .wr_data, .rd_data, .irq);

  // Monitor: compare read data against the scoreboard queue
  always begin
    @(negedge clk);
    #2;
    if (rd_en && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rd_data !== e) begin
        fails++;
        $display("FAIL %s: rd_data=%h expected %h", t, rd_data, e);
      end
    end
  end

  task automatic do_read(input logic sel, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_sel = sel; rd_en = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic do_write(input logic sel, input logic [31:0] d);
    @(negedge clk);
    reg_sel = sel; wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    @(negedge clk);
    #2;
    checks++;
    if (irq !== exp) begin
      fails++;
      $display("FAIL %s: irq=%b expected %b", tag, irq, exp);
    end
  endtask

  initial begin
    // R1: reset values
    chk_irq(1'b0, "R1 irq in reset");
    do_read(1'b0, 32'h0000_0010, "R1 status in reset");
    do_read(1'b1, 32'h0000_000E, "R1 mask in reset");
    @(negedge clk); rst_n = 1'b1;
    // R4: init flag high for INIT_CYCLES edges
    repeat (INIT_CYCLES - 1) @(negedge clk);
    // 7 edges have passed; the read below samples before edge 8
    begin
      reg_sel = 1'b0; rd_en = 1'b1;
      #2; checks++;
      if (rd_data !== 32'h0000_0010) begin
        fails++; $display("FAIL R4 busy before last edge: %h expected %h", rd_data, 32'h10);
      end
      @(negedge clk); #2; checks++;
      if (rd_data !== 32'h0000_0000) begin
        fails++; $display("FAIL R4 done after INIT_CYCLES: %h expected %h", rd_data, 32'h0);
      end
      rd_en = 1'b0;
    end
    // R8: init-done interrupt with default mask; R9 level over several cycles
    chk_irq(1'b1, "R8 init done irq");
    chk_irq(1'b1, "R9 level held");
    // R5: upper bits ignored
    do_write(1'b1, 32'hFFFF_FFF0);
    do_read(1'b1, 32'h0000_0000, "R5 mask after upper-only write");
    chk_irq(1'b0, "R9 mask zero quiet");
    do_write(1'b1, 32'hFFFF_FFFF);
    do_read(1'b1, 32'h0000_000F, "R5 unused mask bits zero");
    // R6: input empty interrupt
    do_write(1'b1, 32'h0000_0001);
    chk_irq(1'b1, "R6 input empty irq");
    @(negedge clk); in_count = 5;
    chk_irq(1'b0, "R6 input ready no irq");
    do_read(1'b0, 32'h0000_4000, "R2 input ready code");
    @(negedge clk); in_count = ICW'(IN_DEPTH);
    do_read(1'b0, 32'h0000_C000, "R2 input full code");
    @(negedge clk); in_count = 1;
    do_read(1'b0, 32'h0000_4000, "R2 count 1 ready");
    // R7: output select
    do_write(1'b1, 32'h0000_0006);
    @(negedge clk); out_count = OCW'(OUT_DEPTH);
    chk_irq(1'b1, "R7 out full irq sel 11");
    do_read(1'b0, 32'h0000_7000, "R3 output full code");
    @(negedge clk); out_count = 3;
    chk_irq(1'b0, "R7 out ready no irq sel 11");
    do_read(1'b0, 32'h0000_5000, "R3 output ready code");
    do_write(1'b1, 32'h0000_0002);
    chk_irq(1'b1, "R7 out ready irq sel 01");
    do_write(1'b1, 32'h0000_0004);
    chk_irq(1'b0, "R7 sel 10 never fires");
    // R9: OR of input-empty and output-ready
    do_write(1'b1, 32'h0000_0003);
    @(negedge clk); in_count = 0; out_count = 0;
    chk_irq(1'b1, "R9 input empty alone");
    @(negedge clk); in_count = 2;
    chk_irq(1'b0, "R9 no condition");
    // R11: sleep bit
    @(negedge clk); sleep_in = 1'b1;
    do_read(1'b0, 32'h0000_4001, "R11 sleep bit");
    // R10: status write ignored
    do_write(1'b0, 32'hFFFF_FFFF);
    do_read(1'b0, 32'h0000_4001, "R10 status write ignored");
    do_read(1'b1, 32'h0000_0003, "R10 mask untouched by status write");
    @(negedge clk); rd_en = 1'b0; #2; checks++;
    if (rd_data !== 32'h0) begin
      fails++; $display("FAIL R10 idle rd_data=%h expected 0", rd_data);
    end
    repeat (3) @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (5000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule